// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Fast/Normal Routing

This block gathers level-sensitive interrupt requests from on-chip peripherals and presents them to the core on two request lines. One line is the normal interrupt and the other is the fast interrupt. Each source has an enable bit and a route bit. The route bit picks which of the two lines the source drives when it is enabled. A third output asks the core to leave idle. A single control bit decides whether that wake request comes from any active source or only from enabled ones.

Sources sit in 32-bit register words. The low word reserves its lowest `SKIP` bit positions, so low source n lives at bit n+`SKIP`. An optional high word holds `HI_SRC` further sources starting at bit 0. The register port gives write access and combinational read access to the enable, route and control registers. Through the same port it exposes raw source levels and per-line pending views. Sources are never cleared by the controller. Software acknowledges a source by disabling it.

Top module: `icu_top`

## Requirements
- R1: After reset the enable, route and control registers read 0, and irq_o, fiq_o and wake_o are 0.
- R2: A high source with its enable bit at 1 and route bit at 0 asserts irq_o. A source whose enable bit is 0 never drives irq_o or fiq_o.
- R3: A route bit of 1 steers its enabled source to fiq_o instead of irq_o.
- R4: Low source n (0 <= n < 32-SKIP) maps to bit n+SKIP of the low-word registers (addresses 0x0-0x4). Bits below SKIP read 0 and ignore writes.
- R5: High source j maps to bit j of the high-word registers (addresses 0x8-0xC). Bits at and above HI_SRC read 0.
- R6: The pending registers (0x0 low, 0x8 high) show the raw source levels and ignore writes.
- R7: The irq-pending view (0x3/0xB) equals pending AND enable AND NOT route. The fiq-pending view (0x4/0xC) equals pending AND enable AND route. Enable is at 0x1/0x9 and route at 0x2/0xA.
- R8: With the idle-control bit (bit 0 of address 0x5) at 1, wake_o is asserted only by enabled pending sources.
- R9: With the idle-control bit at 0, any pending source asserts wake_o, whether enabled or not.
- R10: irq_o, fiq_o and wake_o are registered. They follow a source or register change at the next rising clock edge.
- R11: Requests are level-triggered. An enabled source held high keeps its line asserted. Clearing its enable bit drops the line one cycle later while the source stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32-SKIP+HI_SRC | Source levels, low sources first |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational on address) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Leave-idle request |

## Verification
The bench writes all ones to both enable words. This catches a design that drops the skip offset or the high-word truncation, because the read-back would show bits that do not exist. It runs wake with disabled-but-active sources under both idle-control settings. A design that ignores the control bit either wakes the core spuriously or never wakes it. It samples irq_o within the cycle a source rises and again one edge later, which exposes an unregistered or doubly registered path. It also clears an enable bit while the source stays high, so a design that latched requests would keep the line asserted.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 4;
  // field selector, low three address bits
  localparam logic [2:0] F_PEND = 3'd0;
  localparam logic [2:0] F_EN   = 3'd1;
  localparam logic [2:0] F_RT   = 3'd2;
  localparam logic [2:0] F_IRQP = 3'd3;
  localparam logic [2:0] F_FIQP = 3'd4;
  localparam logic [2:0] F_CTRL = 3'd5;
endpackage

// File: rtl/icu_bank.sv
module icu_bank
  import icu_pkg::*;
#(
  parameter int unsigned OFFSET = 8,
  parameter int unsigned NSRC   = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [2:0]        field_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_any_o,
  output logic              fiq_any_o,
  output logic              pend_any_o,
  output logic              live_any_o
);
  logic [NSRC-1:0] en_q, rt_q, live, irqp, fiqp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      rt_q <= '0;
    end else if (sel_i && we_i) begin
      if (field_i == F_EN) en_q <= wdata_i[OFFSET +: NSRC];
      if (field_i == F_RT) rt_q <= wdata_i[OFFSET +: NSRC];
    end
  end

  assign live = src_i & en_q;
  assign irqp = live & ~rt_q;
  assign fiqp = live & rt_q;

  function automatic logic [WORD_W-1:0] place(input logic [NSRC-1:0] v);
    logic [WORD_W-1:0] w;
    w = '0;
    w[OFFSET +: NSRC] = v;
    return w;
  endfunction

  always_comb begin
    unique case (field_i)
      F_PEND:  rdata_o = place(src_i);
      F_EN:    rdata_o = place(en_q);
      F_RT:    rdata_o = place(rt_q);
      F_IRQP:  rdata_o = place(irqp);
      F_FIQP:  rdata_o = place(fiqp);
      default: rdata_o = '0;
    endcase
  end

  assign irq_any_o  = |irqp;
  assign fiq_any_o  = |fiqp;
  assign pend_any_o = |src_i;
  assign live_any_o = |live;

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && field_i == F_EN) |=> (en_q == $past(wdata_i[OFFSET +: NSRC]))); // R2
  AST_RT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && we_i && field_i == F_RT) |=> $stable(rt_q)); // R3
endmodule

// File: rtl/icu_outreg.sv
module icu_outreg #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int unsigned SKIP   = 8,
  parameter int unsigned HI_SRC = 16,
  localparam int unsigned LO_SRC = WORD_W - SKIP,
  localparam int unsigned NSRC   = LO_SRC + HI_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {1'b0, F_CTRL};

  logic [2:0]        field;
  logic              ctrl_hit, idle_q;
  logic [WORD_W-1:0] lo_rd, hi_rd;
  logic              lo_irq, lo_fiq, lo_pend, lo_live;
  logic              hi_irq, hi_fiq, hi_pend, hi_live;
  logic              any_pend, any_live, wake_d;

  assign field    = reg_addr_i[2:0];
  assign ctrl_hit = (reg_addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  idle_q <= 1'b0;
    else if (reg_we_i && ctrl_hit) idle_q <= reg_wdata_i[0];
  end

  icu_bank #(.OFFSET(SKIP), .NSRC(LO_SRC)) i_lo (
    .clk_i, .rst_ni,
    .src_i      (src_i[LO_SRC-1:0]),
    .sel_i      (!reg_addr_i[3]),
    .we_i       (reg_we_i),
    .field_i    (field),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (lo_rd),
    .irq_any_o  (lo_irq),
    .fiq_any_o  (lo_fiq),
    .pend_any_o (lo_pend),
    .live_any_o (lo_live)
  );

  generate
    if (HI_SRC > 0) begin : g_hi
      icu_bank #(.OFFSET(0), .NSRC(HI_SRC)) i_hi (
        .clk_i, .rst_ni,
        .src_i      (src_i[NSRC-1:LO_SRC]),
        .sel_i      (reg_addr_i[3]),
        .we_i       (reg_we_i),
        .field_i    (field),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (hi_rd),
        .irq_any_o  (hi_irq),
        .fiq_any_o  (hi_fiq),
        .pend_any_o (hi_pend),
        .live_any_o (hi_live)
      );
    end else begin : g_no_hi
      assign hi_rd   = '0;
      assign hi_irq  = 1'b0;
      assign hi_fiq  = 1'b0;
      assign hi_pend = 1'b0;
      assign hi_live = 1'b0;
    end
  endgenerate

  always_comb begin
    if (ctrl_hit)           reg_rdata_o = {{(WORD_W-1){1'b0}}, idle_q};
    else if (reg_addr_i[3]) reg_rdata_o = hi_rd;
    else                    reg_rdata_o = lo_rd;
  end

  assign any_pend = lo_pend | hi_pend;
  assign any_live = lo_live | hi_live;
  // idle bit set: only enabled sources may wake
  assign wake_d   = idle_q ? any_live : any_pend;

  icu_outreg #(.W(3)) i_out (
    .clk_i, .rst_ni,
    .d_i ({lo_irq | hi_irq, lo_fiq | hi_fiq, wake_d}),
    .q_o ({irq_o, fiq_o, wake_o})
  );

  AST_WAKE_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || fiq_o) |-> wake_o); // R8
  AST_IDLE_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_q && any_pend) |=> wake_o); // R9
endmodule

// File: tb/test_icu_top.sv
module test_icu_top;
  localparam int CLK_PERIOD = 10;
  localparam int SKIP = 8;
  localparam int HI_SRC = 16;
  localparam int LO_SRC = 32 - SKIP;
  localparam int NSRC = LO_SRC + HI_SRC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, fiq, wake;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icu_top #(.SKIP(SKIP), .HI_SRC(HI_SRC)) i_icu_top (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic clear_all();
    src = '0;
    wr(4'h1, 0); wr(4'h2, 0); wr(4'h9, 0); wr(4'hA, 0); wr(4'h5, 0);
    step(2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h1, v); chk("R1 en", v, 0);
    rd(4'h2, v); chk("R1 route", v, 0);
    rd(4'h5, v); chk("R1 ctrl", v, 0);
    chk("R1 outs", {29'b0, irq, fiq, wake}, 0);
  endtask

  task automatic t_irq();
    clear_all();
    wr(4'h1, 32'h1 << (3 + SKIP));
    src = '0; src[5] = 1'b1;
    step(2);
    chk("R2 disabled source", {30'b0, irq, fiq}, 0);
    src = '0;
    step(2);
    @(negedge clk);
    src[3] = 1'b1;
    #1 chk("R10 before edge", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R10 after one edge", {31'b0, irq}, 1);
    chk("R2 enabled source irq/fiq", {30'b0, irq, fiq}, 32'b10);
  endtask

  task automatic t_fiq();
    wr(4'h2, 32'h1 << (3 + SKIP));
    step(1);
    chk("R3 routed to fiq", {30'b0, irq, fiq}, 32'b01);
  endtask

  task automatic t_bitpos();
    logic [31:0] v;
    clear_all();
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h1, v); chk("R4 low skip bits", v, 32'hFFFF_FF00);
    wr(4'h1, 0);
  endtask

  task automatic t_hibank();
    logic [31:0] v;
    clear_all();
    wr(4'h9, 32'hFFFF_FFFF);
    rd(4'h9, v); chk("R5 high width", v, 32'h0000_FFFF);
    src[LO_SRC + 2] = 1'b1;
    rd(4'h8, v); chk("R5 high pending bit", v, 32'h4);
    step(2);
    chk("R5 high irq", {31'b0, irq}, 1);
  endtask

  task automatic t_pend_ro();
    logic [31:0] v;
    clear_all();
    src[0] = 1'b1; src[LO_SRC-1] = 1'b1;
    rd(4'h0, v); chk("R6 raw levels", v, 32'h8000_0100);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R6 write ignored", v, 32'h8000_0100);
  endtask

  task automatic t_views();
    logic [31:0] v;
    clear_all();
    wr(4'h1, 32'h7 << SKIP);
    wr(4'h2, 32'h2 << SKIP);
    src[0] = 1'b1; src[1] = 1'b1; src[2] = 1'b1; src[4] = 1'b1;
    rd(4'h3, v); chk("R7 irq view", v, 32'h500);
    rd(4'h4, v); chk("R7 fiq view", v, 32'h200);
  endtask

  task automatic t_wake();
    clear_all();
    wr(4'h5, 1);
    src[7] = 1'b1;
    step(2);
    chk("R8 disabled does not wake", {31'b0, wake}, 0);
    wr(4'h1, 32'h1 << (7 + SKIP));
    step(1);
    chk("R8 enabled wakes", {31'b0, wake}, 1);
    wr(4'h1, 0);
    wr(4'h5, 0);
    step(1);
    chk("R9 any pending wakes", {30'b0, wake, irq}, 32'b10);
  endtask

  task automatic t_ack();
    clear_all();
    wr(4'h1, 32'h1 << (9 + SKIP));
    src[9] = 1'b1;
    step(6);
    chk("R11 held level", {31'b0, irq}, 1);
    @(negedge clk);
    we = 1'b1; addr = 4'h1; wdata = 0;
    @(negedge clk);
    we = 1'b0;
    chk("R11 one cycle after disable", {31'b0, irq}, 1);
    @(negedge clk);
    chk("R11 dropped by disable", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_irq();
    t_fiq();
    t_bitpos();
    t_hibank();
    t_pend_ro();
    t_views();
    t_wake();
    t_ack();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule